// File: doc/BRIEF.md
# Rebindable Input-Device Register Window

This block presents sixteen bytes of address space to a processor-style byte bus. The byte at offset 0 is a view selector. The fifteen bytes at offsets 1 to 15 show the state of whichever input device the selector currently names. The same fifteen data bytes can show either of two keyboard pages, one of up to four gamepad slots, or a combined gamepad view. The combined view ORs the digital controls of every attached pad. Its analog sticks and triggers are taken from the attached pad with the lowest number.

Device state reaches the block already decoded, as parallel vectors with a presence flag for each device. The keyboard arrives as a 256-bit keycode bitmap, and each pad as fifteen bytes. The block does no report parsing. It only stores the selector and multiplexes these vectors. A read request is answered one clock later with a response strobe. The bus carries no back-pressure: every request is accepted in the cycle it is raised, and the response is never stalled. It is up to the requester to take the data in the cycle the strobe is high.

Top module: `devwin_top`

## Requirements
- R1: After reset the selector holds 0x00, which is keyboard page 0. A read of offset 0 then returns 0xC0 when the keyboard is present and 0x00 when it is absent.
- R2: A bus write to offset 0 stores the whole data byte into the selector. Bus writes to offsets 1 to 15 leave the selector unchanged.
- R3: A read request at a clock edge samples the selector and the device inputs at that edge. The next cycle carries rd_valid high and the byte in rd_data. rd_valid is low in every cycle not preceded by a request.
- R4: A read of offset 0 returns the view-valid flag in both bit 7 and bit 6, and selector bits 5:0 in bits 5:0.
- R5: Selector 0x00 is keyboard page 0 and 0x10 is keyboard page 1. Offset k (1 to 15) returns bitmap byte 16*page + k - 1. Keycode K lives at bit (K & 7) of bitmap byte (K >> 3), so the last byte of each page is not shown.
- R6: The keyboard view is valid exactly when kbd_present is 1. While it is invalid, offsets 1 to 15 read 0x00.
- R7: Selectors 0x12, 0x22, 0x32 and 0x42 show pad slots 0 to 3 (players 1 to 4). Offset k returns byte k of that slot. The view is valid only when that slot's presence bit is 1; otherwise the data reads 0x00.
- R8: In every gamepad view, offsets 2 and 11 to 15 read 0x00. Offset 1 holds the D-pad in bits 3:0 and flags in bits 7:6. Offsets 3 and 4 hold the buttons. Offsets 5 to 8 hold the signed stick axes, and offsets 9 and 10 hold the unsigned triggers.
- R9: Selector 0x02 is the combined pad view. It is valid when any pad is present. Its offsets 1, 3 and 4 are the bitwise OR of the bytes of all present pads.
- R10: In the combined view, offsets 5 to 10 come from the lowest-numbered present pad, unmodified.
- R11: A selector with a low nibble other than 0 or 2, a keyboard page above 1, or a pad number above 4 is an unknown view. In that case offset 0 has bits 7:6 clear and every data offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read request |
| rd_valid | output | 1 | Read response strobe, one cycle after bus_rd |
| rd_data | output | 8 | Read response byte |
| kbd_present | input | 1 | Keyboard attached |
| kbd_bitmap | input | 256 | Keycode bitmap, byte j at bits 8j+7:8j |
| pad_present | input | 4 | Attached flag per pad slot |
| pad_bytes | input | 480 | Pad state; byte k of slot p at bits 8(15p+k-1)+7 : 8(15p+k-1) |

## Verification
A corrupted selector shows on the very next read of offset 0, one cycle after the request. It also shows as data taken from the wrong source on every data offset. A fault in the lowest-present-pad search shows only in offsets 5 to 10 of the combined view, and only when pad 0 is absent. The bench therefore runs the combined view with several presence patterns. A presence or unknown-view mistake shows as non-zero data where 0x00 is required, in the same response cycle.

// File: rtl/devwin_pkg.sv
package devwin_pkg;
  localparam int BYTE_W     = 8;
  localparam int WIN_BYTES  = 16;
  localparam int DATA_BYTES = WIN_BYTES - 1;
  localparam int ADDR_W     = $clog2(WIN_BYTES);
  localparam int PAGE_BYTES = 16;

  localparam logic [3:0] KIND_KBD = 4'h0;
  localparam logic [3:0] KIND_PAD = 4'h2;

  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_KBD   = 2'd1,
    VIEW_SLOT  = 2'd2,
    VIEW_MERGE = 2'd3
  } view_e;

  // offset k in 1..15: gamepad byte with a meaning
  function automatic logic pad_off_defined(input int k);
    return (k == 1) || (k == 3) || (k == 4) || (k >= 5 && k <= 10);
  endfunction

  // offset k carries an analog quantity (stick axis or trigger)
  function automatic logic pad_off_analog(input int k);
    return (k >= 5) && (k <= 10);
  endfunction
endpackage

// File: rtl/devwin_sel_reg.sv
module devwin_sel_reg
  import devwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] sel_q
);
  logic hit;
  assign hit = bus_wr && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)   sel_q <= '0;
    else if (hit) sel_q <= bus_wdata;
  end
endmodule

// File: rtl/devwin_decode.sv
module devwin_decode
  import devwin_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int NUM_PADS  = 4
) (
  input  logic [BYTE_W-1:0] sel,
  output view_e             kind,
  output logic [3:0]        unit
);
  logic [3:0] lo, hi;
  assign lo = sel[3:0];
  assign hi = sel[7:4];

  always_comb begin
    kind = VIEW_NONE;
    unit = '0;
    if (lo == KIND_KBD) begin
      if (int'(hi) < NUM_PAGES) begin
        kind = VIEW_KBD;
        unit = hi;
      end
    end else if (lo == KIND_PAD) begin
      if (hi == 4'd0) begin
        kind = VIEW_MERGE;
      end else if (int'(hi) <= NUM_PADS) begin
        kind = VIEW_SLOT;
        unit = hi - 4'd1;
      end
    end
  end
endmodule

// File: rtl/devwin_kbd_page.sv
module devwin_kbd_page
  import devwin_pkg::*;
#(
  parameter int KBD_BYTES = 32,
  localparam int NUM_PAGES = KBD_BYTES / PAGE_BYTES
) (
  input  logic [KBD_BYTES*BYTE_W-1:0]  bitmap,
  input  logic [3:0]                   page,
  output logic [DATA_BYTES*BYTE_W-1:0] page_data
);
  logic [BYTE_W-1:0] pick [DATA_BYTES];

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    always_comb begin
      pick[b] = '0;
      for (int p = 0; p < NUM_PAGES; p++) begin
        if (int'(page) == p)
          pick[b] = bitmap[(p*PAGE_BYTES + b)*BYTE_W +: BYTE_W];
      end
    end
    assign page_data[b*BYTE_W +: BYTE_W] = pick[b];
  end
endmodule

// File: rtl/devwin_pad_merge.sv
module devwin_pad_merge
  import devwin_pkg::*;
#(
  parameter int NUM_PADS = 4,
  localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic [NUM_PADS*DATA_BYTES*BYTE_W-1:0] pad_bytes,
  input  logic [NUM_PADS-1:0]                   pad_present,
  output logic [DATA_BYTES*BYTE_W-1:0]          merged,
  output logic                                  any_present
);
  logic [IDX_W-1:0] low_idx;

  // lowest-numbered attached pad owns the analog bytes
  always_comb begin
    low_idx = '0;
    for (int p = NUM_PADS - 1; p >= 0; p--) begin
      if (pad_present[p]) low_idx = IDX_W'(p);
    end
  end

  assign any_present = |pad_present;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    localparam int OFF = b + 1;
    logic [BYTE_W-1:0] val;
    if (!pad_off_defined(OFF)) begin : g_undef
      assign val = '0;
    end else if (pad_off_analog(OFF)) begin : g_analog
      always_comb begin
        val = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
          if (int'(low_idx) == p && any_present)
            val = pad_bytes[(p*DATA_BYTES + b)*BYTE_W +: BYTE_W];
        end
      end
    end else begin : g_digital
      always_comb begin
        val = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
          if (pad_present[p])
            val = val | pad_bytes[(p*DATA_BYTES + b)*BYTE_W +: BYTE_W];
        end
      end
    end
    assign merged[b*BYTE_W +: BYTE_W] = val;
  end
endmodule

// File: rtl/devwin_top.sv
module devwin_top
  import devwin_pkg::*;
#(
  parameter int KBD_BYTES = 32,
  parameter int NUM_PADS  = 4,
  localparam int NUM_PAGES = KBD_BYTES / PAGE_BYTES,
  localparam int PAD_W     = NUM_PADS * DATA_BYTES * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [BYTE_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic                        rd_valid,
  output logic [BYTE_W-1:0]           rd_data,
  input  logic                        kbd_present,
  input  logic [KBD_BYTES*BYTE_W-1:0] kbd_bitmap,
  input  logic [NUM_PADS-1:0]         pad_present,
  input  logic [PAD_W-1:0]            pad_bytes
);
  logic [BYTE_W-1:0]            sel_q;
  view_e                        kind;
  logic [3:0]                   unit;
  logic [DATA_BYTES*BYTE_W-1:0] kbd_view;
  logic [DATA_BYTES*BYTE_W-1:0] merge_view;
  logic                         any_pad;
  logic [BYTE_W-1:0]            slot_b [DATA_BYTES];
  logic [BYTE_W-1:0]            view_b [DATA_BYTES];
  logic                         slot_on;
  logic                         view_ok;
  logic [BYTE_W-1:0]            win_byte;

  devwin_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sel_q(sel_q)
  );

  devwin_decode #(.NUM_PAGES(NUM_PAGES), .NUM_PADS(NUM_PADS)) u_dec (
    .sel(sel_q), .kind(kind), .unit(unit)
  );

  devwin_kbd_page #(.KBD_BYTES(KBD_BYTES)) u_kbd (
    .bitmap(kbd_bitmap), .page(unit), .page_data(kbd_view)
  );

  devwin_pad_merge #(.NUM_PADS(NUM_PADS)) u_merge (
    .pad_bytes(pad_bytes), .pad_present(pad_present),
    .merged(merge_view), .any_present(any_pad)
  );

  always_comb begin
    slot_on = 1'b0;
    for (int p = 0; p < NUM_PADS; p++)
      if (int'(unit) == p) slot_on = pad_present[p];
  end

  // one selected slot, undefined offsets forced to zero
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_slot
    if (!pad_off_defined(b + 1)) begin : g_undef
      assign slot_b[b] = '0;
    end else begin : g_def
      always_comb begin
        slot_b[b] = '0;
        for (int p = 0; p < NUM_PADS; p++)
          if (int'(unit) == p)
            slot_b[b] = pad_bytes[(p*DATA_BYTES + b)*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    case (kind)
      VIEW_KBD:   view_ok = kbd_present;
      VIEW_SLOT:  view_ok = slot_on;
      VIEW_MERGE: view_ok = any_pad;
      default:    view_ok = 1'b0;
    endcase
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_view
    always_comb begin
      view_b[b] = '0;
      if (view_ok) begin
        case (kind)
          VIEW_KBD:   view_b[b] = kbd_view[b*BYTE_W +: BYTE_W];
          VIEW_SLOT:  view_b[b] = slot_b[b];
          VIEW_MERGE: view_b[b] = merge_view[b*BYTE_W +: BYTE_W];
          default:    view_b[b] = '0;
        endcase
      end
    end
  end

  always_comb begin
    if (bus_addr == '0) win_byte = {view_ok, view_ok, sel_q[5:0]};
    else                win_byte = view_b[bus_addr - ADDR_W'(1)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= win_byte;
    end
  end
endmodule

// File: rtl/devwin_chk.sv
module devwin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic       bus_rd,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       kbd_present,
  input logic [7:0] sel_q
);
  assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd0) |=> (sel_q == $past(bus_wdata)));

  assert_sel_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 4'd0) |=> $stable(sel_q));

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_rd));

  assert_valid_twin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_addr) == 4'd0) |-> (rd_data[7] == rd_data[6]));

  assert_kbd_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_addr) != 4'd0 && $past(sel_q[3:0]) == 4'h0 && !$past(kbd_present))
      |-> (rd_data == 8'h00));

  assert_unknown_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_addr) != 4'd0 && $past(sel_q[3:0]) != 4'h0 && $past(sel_q[3:0]) != 4'h2)
      |-> (rd_data == 8'h00));
endmodule

bind devwin_top devwin_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_valid(rd_valid),
  .rd_data(rd_data), .kbd_present(kbd_present), .sel_q(sel_q)
);

// File: tb/devwin_top_tb_top.sv
module devwin_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic         bus_rd = 1'b0;
  logic         rd_valid;
  logic [7:0]   rd_data;
  logic         kbd_present = 1'b1;
  logic [255:0] kbd_bitmap = '0;
  logic [3:0]   pad_present = '0;
  logic [479:0] pad_bytes = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_sel = 8'h00;

  always #10 clk = ~clk;

  devwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_valid(rd_valid),
    .rd_data(rd_data), .kbd_present(kbd_present), .kbd_bitmap(kbd_bitmap),
    .pad_present(pad_present), .pad_bytes(pad_bytes)
  );

  function automatic logic [7:0] pb(input int p, input int k);
    return pad_bytes[(p*15 + k - 1)*8 +: 8];
  endfunction

  function automatic logic pad_def(input int k);
    return (k == 1) || (k == 3) || (k == 4) || (k >= 5 && k <= 10);
  endfunction

  // expected window byte derived from the requirements
  function automatic logic [7:0] model(input logic [7:0] s, input int off);
    int h;
    int t;
    int low;
    logic v;
    logic [7:0] d;
    h = int'(s[7:4]);
    t = int'(s[3:0]);
    v = 1'b0;
    d = 8'h00;
    low = -1;
    for (int p = 3; p >= 0; p--) if (pad_present[p]) low = p;
    if (t == 0 && h < 2) begin
      v = kbd_present;
      if (off > 0) d = kbd_bitmap[(h*16 + off - 1)*8 +: 8];
    end else if (t == 2 && h >= 1 && h <= 4) begin
      v = pad_present[h-1];
      if (off > 0 && pad_def(off)) d = pb(h-1, off);
    end else if (t == 2 && h == 0) begin
      v = |pad_present;
      if (off >= 5 && off <= 10) begin
        if (low >= 0) d = pb(low, off);
      end else if (off > 0 && pad_def(off)) begin
        for (int p = 0; p < 4; p++) if (pad_present[p]) d = d | pb(p, off);
      end
    end
    if (off == 0) return {v, v, s[5:0]};
    return v ? d : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int off, input logic [7:0] v);
    @(negedge clk);
    bus_addr = 4'(off); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (off == 0) cur_sel = v;
  endtask

  task automatic bus_read(input int off, output logic [7:0] v, output logic ok);
    @(negedge clk);
    bus_addr = 4'(off); bus_rd = 1'b1;
    @(negedge clk);
    v = rd_data; ok = rd_valid;
    bus_rd = 1'b0;
  endtask

  task automatic sweep(input string req, input int first, input int last);
    logic [7:0] v;
    logic ok;
    for (int k = first; k <= last; k++) begin
      bus_read(k, v, ok);
      check(req, {7'd0, ok}, 8'h01);
      check(req, v, model(cur_sel, k));
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    logic ok;
    check("R3 idle", {7'd0, rd_valid}, 8'h00);
    bus_read(0, v, ok);
    check("R1 reset select", v, 8'hC0);
    bus_read(1, v, ok);
    check("R1 page0 byte0", v, kbd_bitmap[7:0]);
  endtask

  task automatic t_select;
    logic [7:0] v;
    logic ok;
    bus_write(0, 8'h10);
    bus_read(0, v, ok);
    check("R2 select write", v, 8'hD0);
    bus_write(5, 8'h33);
    bus_read(0, v, ok);
    check("R2 data offset write ignored", v, 8'hD0);
    @(negedge clk);
    check("R3 no response without request", {7'd0, rd_valid}, 8'h00);
  endtask

  task automatic t_keyboard;
    logic [7:0] v;
    logic ok;
    for (int j = 0; j < 32; j++) kbd_bitmap[j*8 +: 8] = 8'(j*37 + 5);
    bus_write(0, 8'h00);
    sweep("R5 page0", 0, 15);
    bus_write(0, 8'h10);
    sweep("R5 page1", 1, 15);
    kbd_bitmap = '0;
    kbd_bitmap[8'h04] = 1'b1;
    kbd_bitmap[8'h9A] = 1'b1;
    bus_write(0, 8'h00);
    bus_read(1, v, ok);
    check("R5 keycode 04", v, 8'h10);
    bus_write(0, 8'h10);
    bus_read(4, v, ok);
    check("R5 keycode 9A", v, 8'h04);
    kbd_present = 1'b0;
    bus_read(4, v, ok);
    check("R6 absent data", v, 8'h00);
    bus_read(0, v, ok);
    check("R6 absent flag", v, 8'h10);
    kbd_present = 1'b1;
  endtask

  task automatic t_players;
    for (int p = 0; p < 4; p++)
      for (int k = 1; k <= 15; k++) pad_bytes[(p*15 + k - 1)*8 +: 8] = 8'(p*61 + k*23 + 9);
    pad_present = 4'b1011;
    for (int n = 1; n <= 4; n++) begin
      bus_write(0, 8'((n << 4) | 2));
      sweep((n == 3) ? "R7 absent slot" : "R8 R7 slot", 0, 15);
    end
  endtask

  task automatic t_merged;
    bus_write(0, 8'h02);
    pad_present = 4'b1101;
    sweep("R9 R10 merge p0", 0, 15);
    pad_present = 4'b1100;
    sweep("R10 merge low pad 2", 0, 15);
    pad_present = 4'b1000;
    sweep("R10 merge only pad 3", 1, 10);
    pad_present = 4'b0000;
    sweep("R9 merge none", 0, 6);
  endtask

  task automatic t_unknown;
    logic [7:0] v;
    logic ok;
    logic [7:0] bad [4] = '{8'h01, 8'h20, 8'h52, 8'h3F};
    pad_present = 4'b1111;
    for (int i = 0; i < 4; i++) begin
      bus_write(0, bad[i]);
      bus_read(0, v, ok);
      check("R11 unknown flag", v, {2'b00, bad[i][5:0]});
      bus_read(3, v, ok);
      check("R11 unknown data", v, 8'h00);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int j = 0; j < 32; j++) kbd_bitmap[j*8 +: 8] = 8'(j + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_keyboard();
    t_players();
    t_merged();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule